// File: doc/BRIEF.md
# Staged-Update Crosspoint Switch

This block connects 64 single-bit data inputs to 64 single-bit data outputs. Each output has its own selector, so any input can feed any number of outputs at once. A route has two parts: the index of the source input and a disable bit. A disabled output drives 0.

Route changes are made in two steps. First, a write port places a new route into the staging register of one output. Nothing visible changes at this point. Then a single commit pulse copies every staging register into the live route registers on the same clock edge. Because of this, a large reconfiguration never shows a half-updated connection map.

A mode pin chooses how the outputs are driven. In combinational mode each output follows its selected input directly. In registered mode each output is captured on the rising clock edge. A debug port reads back the live route of any one output and also shows what that output's selector is producing.

Top module: `xbar_switch`

## Requirements
- R1: While `rst_n` is low, every staging route and every live route is set to source 0 with the disable bit at 1. As a result, all of `dout` is 0 after reset.
- R2: An output whose live disable bit is 1 drives 0 whatever its inputs are.
- R3: On a rising edge with `wr_en` high, the route {`wr_off`, `wr_src`} is written into the staging register selected by `wr_addr`, and only that one. Live routes, `dout` and the readback value do not change because of the write.
- R4: On a rising edge with `commit` high, all 64 live routes take their staging values together. On an edge with `commit` low, the live routes are held.
- R5: When `wr_en` and `commit` are high on the same edge, the commit copies the staging contents from before that edge. The new write reaches the live routes only at a later commit.
- R6: With `clocked_mode` low, output k equals `din[src_k]` combinationally whenever output k is enabled.
- R7: With `clocked_mode` high, output k shows the value its selector produced at the previous rising edge. That value is 0 if output k was disabled at that edge.
- R8: With `tst_en` high, `tst_cfg` shows the live route of output `tst_sel`. Bit 6 is the disable bit and bits 5:0 are the source index. With `tst_en` low, `tst_cfg` is 0.
- R9: With `tst_en` high, `tst_obs` shows the current combinational selector result of output `tst_sel`, taken before the output register. With `tst_en` low, `tst_obs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes and output register sample on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clocked_mode | input | 1 | 1 = registered outputs, 0 = combinational outputs |
| din | input | 64 | Data inputs |
| wr_en | input | 1 | Write one staging register |
| wr_addr | input | 6 | Output whose staging register is written |
| wr_src | input | 6 | Source input index to stage |
| wr_off | input | 1 | Disable bit to stage |
| commit | input | 1 | Copy all staging registers into the live routes |
| tst_en | input | 1 | Enable the readback outputs |
| tst_sel | input | 6 | Output whose live route is read back |
| dout | output | 64 | Data outputs |
| tst_cfg | output | 7 | Readback: {disable, source} |
| tst_obs | output | 1 | Readback: selector result of the chosen output |

## Verification
The assertions assume that the strobes, the addresses and the mode pin hold known values at every rising edge once reset is released. They also assume that reset is asserted only once, at the start. The registered-mode check further relies on the selector result seen at one edge being the value that the output register captured at that edge. This holds only if `din` does not change in a window around the edge. The stimulus keeps within all of this: every input changes only on the falling edge, reset is applied once from time zero, and every control pin is driven to 0 or 1 before the first edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int XBAR_SEL_W = 6;

    typedef struct packed {
        logic                  off;
        logic [XBAR_SEL_W-1:0] src;
    } route_t;

    localparam route_t ROUTE_RST = '{off: 1'b1, src: '0};

endpackage

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank
    import xbar_pkg::*;
#(
    parameter int N_PORTS = 64,
    parameter int SEL_W   = XBAR_SEL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_addr,
    input  route_t                     wr_route,
    input  logic                       commit,
    output route_t [N_PORTS-1:0]       active_o
);

    typedef struct packed {
        route_t [N_PORTS-1:0] stage;
        route_t [N_PORTS-1:0] live;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) st_d.live = st_q.stage;
        if (wr_en)  st_d.stage[wr_addr] = wr_route;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage <= {N_PORTS{ROUTE_RST}};
            st_q.live  <= {N_PORTS{ROUTE_RST}};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.live;

    // R3: a write lands in the addressed staging register
    assert_stage_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.stage[$past(wr_addr)] == $past(wr_route));

    // R4 and R5: a commit copies the staging contents sampled before the edge
    assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> st_q.live == $past(st_q.stage));

    // R4: without a commit the live routes hold
    assert_live_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.live));

endmodule

// File: rtl/xbar_out_slice.sv
module xbar_out_slice
    import xbar_pkg::*;
#(
    parameter int N_IN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  din,
    input  route_t           route_i,
    input  logic             clocked_mode,
    output logic             mux_o,
    output logic             dout_o
);

    logic out_d, out_q;

    always_comb begin
        mux_o = route_i.off ? 1'b0 : din[route_i.src];
        out_d = mux_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign dout_o = clocked_mode ? out_q : mux_o;

    // R2: a disabled output in combinational mode is quiet
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clocked_mode && route_i.off) |-> !dout_o);

    // R7: in registered mode the output is the selector result of the previous edge
    assert_reg_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clocked_mode |-> dout_o == $past(mux_o));

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
    import xbar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clocked_mode,
    input  logic [63:0] din,
    input  logic        wr_en,
    input  logic [5:0]  wr_addr,
    input  logic [5:0]  wr_src,
    input  logic        wr_off,
    input  logic        commit,
    input  logic        tst_en,
    input  logic [5:0]  tst_sel,
    output logic [63:0] dout,
    output logic [6:0]  tst_cfg,
    output logic        tst_obs
);

    localparam int SEL_W   = XBAR_SEL_W;
    localparam int N_PORTS = 1 << SEL_W;

    route_t [N_PORTS-1:0] live_w;
    logic   [N_PORTS-1:0] mux_w;
    route_t               wr_route_w;

    assign wr_route_w = '{off: wr_off, src: wr_src};

    xbar_cfg_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_route (wr_route_w),
        .commit   (commit),
        .active_o (live_w)
    );

    for (genvar g = 0; g < N_PORTS; g++) begin : g_out
        xbar_out_slice #(.N_IN(N_PORTS)) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .din          (din),
            .route_i      (live_w[g]),
            .clocked_mode (clocked_mode),
            .mux_o        (mux_w[g]),
            .dout_o       (dout[g])
        );
    end

    always_comb begin
        tst_cfg = tst_en ? live_w[tst_sel] : '0;
        tst_obs = tst_en & mux_w[tst_sel];
    end

    // R8 and R9: readback is silent while the debug port is off
    assert_tst_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_en |-> (tst_cfg == 7'd0 && !tst_obs));

endmodule

// File: tb/xbar_switch_bench.sv
`timescale 1ns/1ps
module xbar_switch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clocked_mode = 1'b0;
    logic [63:0] din = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [5:0]  wr_src = '0;
    logic        wr_off = 1'b0;
    logic        commit = 1'b0;
    logic        tst_en = 1'b0;
    logic [5:0]  tst_sel = '0;
    logic [63:0] dout;
    logic [6:0]  tst_cfg;
    logic        tst_obs;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    xbar_switch u_xbar_switch (
        .clk(clk), .rst_n(rst_n), .clocked_mode(clocked_mode), .din(din),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_src(wr_src), .wr_off(wr_off),
        .commit(commit), .tst_en(tst_en), .tst_sel(tst_sel),
        .dout(dout), .tst_cfg(tst_cfg), .tst_obs(tst_obs)
    );

    // Reference model: plain integer arrays
    int hold_src [64];
    bit hold_off [64];
    int ctl_src  [64];
    bit ctl_off  [64];
    bit dreg     [64];

    function automatic bit sel_val(int k);
        return ctl_off[k] ? 1'b0 : din[ctl_src[k]];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 64; k++) begin
            hold_src[k] = 0; hold_off[k] = 1;
            ctl_src[k]  = 0; ctl_off[k]  = 1;
            dreg[k]     = 0;
        end
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            for (int k = 0; k < 64; k++) dreg[k] = sel_val(k);
            if (commit)
                for (int k = 0; k < 64; k++) begin
                    ctl_src[k] = hold_src[k];
                    ctl_off[k] = hold_off[k];
                end
            if (wr_en) begin
                hold_src[wr_addr] = wr_src;
                hold_off[wr_addr] = wr_off;
            end
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [63:0] e;
        logic [6:0]  ec;
        logic        eo;
        for (int k = 0; k < 64; k++) e[k] = clocked_mode ? dreg[k] : sel_val(k);
        ec = tst_en ? {ctl_off[tst_sel], 6'(ctl_src[tst_sel])} : 7'd0;
        eo = tst_en ? sel_val(tst_sel) : 1'b0;
        if (!rst_n)            check("R1 dout in reset", dout, e);
        else if (clocked_mode) check("R7/R2/R4 registered dout", dout, e);
        else                   check("R6/R2/R4 combinational dout", dout, e);
        check("R8 tst_cfg readback", {57'd0, tst_cfg}, {57'd0, ec});
        check("R9 tst_obs", {63'd0, tst_obs}, {63'd0, eo});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle_ctrl();
        wr_en = 0; commit = 0;
    endtask

    task automatic rand_obs();
        din     = {$urandom, $urandom};
        tst_en  = ($urandom % 4) != 0;
        tst_sel = 6'($urandom);
    endtask

    initial begin
        // R1: reset state
        tst_en = 1; tst_sel = 6'd9; din = '1;
        repeat (3) tick();
        check("R1 readback in reset", {57'd0, tst_cfg}, 64'h40);
        @(negedge clk) rst_n = 1;
        tick();
        check("R1 dout after reset", dout, 64'd0);
        clocked_mode = 1; tick();
        check("R1 registered dout after reset", dout, 64'd0);
        clocked_mode = 0;

        // R3: stage a reversed map; nothing live moves
        for (int k = 0; k < 64; k++) begin
            wr_en = 1; wr_addr = 6'(k); wr_src = 6'(63 - k); wr_off = 0;
            rand_obs();
            tick();
        end
        idle_ctrl();
        check("R3 staged writes leave dout quiet", dout, 64'd0);

        // R4: commit the whole map
        commit = 1; tick(); commit = 0;
        din = 64'h0123_4567_89AB_CDEF; tick();
        for (int k = 0; k < 64; k++) begin
            rand_obs();
            tick();
        end

        // R7: registered mode
        clocked_mode = 1;
        for (int k = 0; k < 30; k++) begin
            rand_obs();
            tick();
        end

        // R4: broadcast input 17 to every output
        clocked_mode = 0;
        for (int k = 0; k < 64; k++) begin
            wr_en = 1; wr_addr = 6'(k); wr_src = 6'd17; wr_off = 0;
            tick();
        end
        wr_en = 0; commit = 1; tick(); commit = 0;
        din = 64'h0000_0000_0002_0000; tick();
        check("R4 broadcast all high", dout, '1);
        din = ~64'h0000_0000_0002_0000; tick();
        check("R4 broadcast all low", dout, 64'd0);

        // R5: write and commit on the same edge
        wr_en = 1; wr_addr = 6'd4; wr_src = 6'd2; wr_off = 0; commit = 1;
        din = 64'h4; tick();
        idle_ctrl(); tst_en = 1; tst_sel = 6'd4; tick();
        check("R5 same-edge commit keeps old route", {57'd0, tst_cfg}, 64'd17);
        commit = 1; tick(); commit = 0; tick();
        check("R5 route live after later commit", {57'd0, tst_cfg}, 64'd2);

        // R2: disable a few outputs
        for (int k = 0; k < 8; k++) begin
            wr_en = 1; wr_addr = 6'(k * 5); wr_src = 6'($urandom); wr_off = 1;
            tick();
        end
        wr_en = 0; commit = 1; tick(); commit = 0;
        din = '1; tst_en = 1; tst_sel = 6'd10; tick();
        check("R2 disabled output quiet", {63'd0, dout[10]}, 64'd0);

        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            wr_en        = ($urandom % 2) != 0;
            wr_addr      = 6'($urandom);
            wr_src       = 6'($urandom);
            wr_off       = ($urandom % 4) == 0;
            commit       = ($urandom % 5) == 0;
            clocked_mode = ($urandom % 3) == 0;
            rand_obs();
            tick();
        end
        idle_ctrl();
        tst_en = 0; tick();
        check("R8 readback off", {57'd0, tst_cfg}, 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule